// File: doc/BRIEF.md
# Programmable pulse generator timer

This block is a 16-bit up-counter with two compare registers that together produce a periodic rectangular wave on one output pin. The period register fixes the cycle length: when the counter reaches it on a counting cycle, the counter returns to zero and keeps going. The duty register marks a point inside the cycle. Reaching it does not disturb the counter.

A single level flip-flop inverts on every match of either register, so the pin is high for one part of each period and low for the other. Each register also raises its own one-cycle interrupt pulse.

Software chooses the flip-flop's starting level while the timer is stopped, using separate set and clear strobes. An output enable gates the level onto the pin. The counter advances only on cycles where the count-clock enable from an external prescaler is high. Correct waveforms need 0 < duty < period ≤ 0xFFFF.

Top module: `ppg_timer`

## Requirements
- R1: After reset, `count` is 0, `pulse_out` is 0, and both interrupt outputs are 0.
- R2: While `run` is high, `count` increases by one on each clock edge where `cnt_en` is high. It holds its value on edges where `cnt_en` is low.
- R3: On a counting edge where `count` equals the period value, `count` becomes 0 instead of incrementing.
- R4: On a counting edge where `count` equals the duty value, the counter still increments, and `irq_duty` is high for exactly the next clock cycle.
- R5: On a counting edge where `count` equals the period value, `irq_period` is high for exactly the next clock cycle.
- R6: The level flip-flop inverts on every counting edge that matches either compare register. With `out_en` high, `pulse_out` shows its level.
- R7: While `out_en` is low, `pulse_out` is 0, and the flip-flop keeps inverting on matches. When the enable returns, the pin shows the level advanced by every match that happened while it was low.
- R8: While `run` is low, `count` is held at 0. A high on `lvl_set` loads level 1 and a high on `lvl_clr` loads level 0; set wins if both are high. The flip-flop follows the loaded level from the next edge. Both strobes have no effect while `run` is high.
- R9: When `run` rises, counting starts from 0 with the flip-flop at the loaded level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable from the prescaler |
| run | input | 1 | High to count, low to stop and hold at zero |
| wr_period | input | 1 | Loads `wr_data` into the period register |
| wr_duty | input | 1 | Loads `wr_data` into the duty register |
| wr_data | input | 16 | Compare value to write |
| lvl_set | input | 1 | Sets the loaded level to 1 while stopped |
| lvl_clr | input | 1 | Sets the loaded level to 0 while stopped |
| out_en | input | 1 | Gates the flip-flop level onto `pulse_out` |
| count | output | 16 | Current counter value |
| pulse_out | output | 1 | Generated waveform |
| irq_period | output | 1 | One-cycle pulse after a period match |
| irq_duty | output | 1 | One-cycle pulse after a duty match |

## Verification
The assertions check, on every cycle, that the counter holds between enables, returns to zero after a period match, and sits at zero while stopped. They also check that each interrupt pulse agrees with the counter value that follows it, and that the flip-flop inverts whenever exactly one interrupt fires.

The overall waveform can only be shown by the bench's sweeps over period, duty, prescale ratio and starting level. These cover the pin level over several periods, the level carried through a masked interval, strobes ignored while running, and the restart state.

// File: rtl/ppg_timer.sv
module ppg_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         run,
  input  logic         wr_period,
  input  logic         wr_duty,
  input  logic [W-1:0] wr_data,
  input  logic         lvl_set,
  input  logic         lvl_clr,
  input  logic         out_en,
  output logic [W-1:0] count,
  output logic         pulse_out,
  output logic         irq_period,
  output logic         irq_duty
);
  localparam logic [W-1:0] PERIOD_RST = '1;
  localparam logic [W-1:0] DUTY_RST   = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] cnt_q, period_q, duty_q;
  logic         lvl_q, ff_q;

  wire step    = run & cnt_en;
  wire hit_p   = step & (cnt_q == period_q);
  wire hit_d   = step & (cnt_q == duty_q);
  wire lvl_nxt = run ? lvl_q : (lvl_set | (lvl_q & ~lvl_clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      period_q   <= PERIOD_RST;
      duty_q     <= DUTY_RST;
      lvl_q      <= 1'b0;
      ff_q       <= 1'b0;
      irq_period <= 1'b0;
      irq_duty   <= 1'b0;
    end else begin
      if (wr_period) period_q <= wr_data;
      if (wr_duty)   duty_q   <= wr_data;
      lvl_q <= lvl_nxt;
      if (!run)       cnt_q <= '0;
      else if (hit_p) cnt_q <= '0;
      else if (step)  cnt_q <= cnt_q + 1'b1;
      ff_q       <= run ? (ff_q ^ hit_p ^ hit_d) : lvl_nxt;
      irq_period <= hit_p;
      irq_duty   <= hit_d;
    end
  end

  assign count     = cnt_q;
  assign pulse_out = out_en & ff_q;
endmodule

module ppg_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         run,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] period_q,
  input logic [W-1:0] duty_q,
  input logic         ff_q,
  input logic         irq_period,
  input logic         irq_duty
);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cnt_en |=> $stable(cnt_q));

  // R3
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && cnt_en && cnt_q == period_q |=> cnt_q == '0);

  // R4
  duty_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_duty && !irq_period |-> cnt_q == $past(duty_q) + {{(W-1){1'b0}}, 1'b1});

  // R5
  period_irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |-> cnt_q == '0);

  // R6
  match_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_period ^ irq_duty) |-> ff_q != $past(ff_q));

  // R8
  stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

bind ppg_timer ppg_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run(run),
  .cnt_q(cnt_q), .period_q(period_q), .duty_q(duty_q), .ff_q(ff_q),
  .irq_period(irq_period), .irq_duty(irq_duty)
);

// File: tb/ppg_timer_bench.sv
module ppg_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 0, run = 0, wr_period = 0, wr_duty = 0;
  logic [15:0] wr_data = '0;
  logic lvl_set = 0, lvl_clr = 0, out_en = 0;
  logic [15:0] count;
  logic pulse_out, irq_period, irq_duty;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ppg_timer u_ppg_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run(run),
    .wr_period(wr_period), .wr_duty(wr_duty), .wr_data(wr_data),
    .lvl_set(lvl_set), .lvl_clr(lvl_clr), .out_en(out_en),
    .count(count), .pulse_out(pulse_out),
    .irq_period(irq_period), .irq_duty(irq_duty)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic run_cfg(input int p, input int d, input int div, input bit lvl);
    int m, k, cyc, n;
    bit last, ffx;
    m = p + 1;
    n = 3 * m;
    wr_data = 16'(p); wr_period = 1;
    @(negedge clk); wr_period = 0; wr_data = 16'(d); wr_duty = 1;
    @(negedge clk); wr_duty = 0;
    if (lvl) begin lvl_set = 1; lvl_clr = 1; end
    else lvl_clr = 1;
    @(negedge clk); lvl_set = 0; lvl_clr = 0; out_en = 1;
    chk("R8", "loaded level", int'(pulse_out), int'(lvl));
    chk("R8", "stopped count", int'(count), 0);
    run = 1; k = 0; cyc = 0; last = 0;
    while (k < n) begin
      ffx = lvl ^ bit'(((k / m) + ((k + p - d) / m)) & 1);
      chk(k == 0 ? "R9" : (last && k % m == 0 ? "R3" : "R2"), "count",
          int'(count), k % m);
      chk(k == 0 ? "R9" : (out_en ? "R6" : "R7"), "pin",
          int'(pulse_out), int'(out_en & ffx));
      chk("R5", "irq_period", int'(irq_period), int'(last && k > 0 && k % m == 0));
      chk("R4", "irq_duty", int'(irq_duty), int'(last && k > 0 && (k - 1) % m == d));
      cnt_en = (cyc % div == div - 1);
      out_en = !(k >= m && k < 2 * m);
      if (cyc == 3) begin lvl_set = !lvl; lvl_clr = lvl; end
      @(posedge clk);
      last = cnt_en;
      if (cnt_en) k++;
      cyc++;
      @(negedge clk);
      lvl_set = 0; lvl_clr = 0;
    end
    run = 0; cnt_en = 0; out_en = 1;
    @(negedge clk);
    chk("R8", "count after stop", int'(count), 0);
    chk("R8", "level after stop ignores run strobes", int'(pulse_out), int'(lvl));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "count", int'(count), 0);
    chk("R1", "pin", int'(pulse_out), 0);
    chk("R1", "irq_period", int'(irq_period), 0);
    chk("R1", "irq_duty", int'(irq_duty), 0);
    rst_n = 1;
    @(negedge clk);
    for (int p = 2; p <= 5; p++)
      for (int d = 1; d < p; d++)
        for (int div = 1; div <= 3; div++)
          for (int l = 0; l < 2; l++)
            run_cfg(p, d, div, bit'(l));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule